// File: doc/BRIEF.md
# Flash Control Register with Mode Interlocks

This block holds the 8-bit control register that steers a small on-chip flash array through program, erase, verify-read and high-voltage phases. A CPU writes and reads it through a plain register port. The block filters every write through hardware interlocks, so no sequence of writes can produce an illegal combination of mode bits. It also turns the register fields into the signals the array and the charge pump need: a divided pump clock enable, and the start and length of the region that an erase will clear.

The erase region comes from an address that the block watches on the array write path. While erase mode is selected and high voltage is off, any write into the array records its byte offset. The recorded offset is then aligned down to the selected erase granule. The block also times array reads. A normal read completes one cycle after it starts. A read issued while verify mode is active is held for a fixed number of extra cycles, so that the weaker cell current can be sensed.

The array-write snoop and the read-start pin have no back-pressure. The block samples them on every cycle and never stalls the array side. A read start that arrives while a read is still in flight is dropped.

Top module: `fctl_top`

## Requirements
- R1: After reset, all eight register bits read as 0. The erase size reads as the full array, the erase base reads as 0, and no read is busy.
- R2: The register layout is fixed, from bit 7 down to bit 0: pump divide [7:6], erase span [5:4], high-voltage on [3], verify read [2], erase mode [1], program mode [0]. A read returns the stored value the cycle after a write.
- R3: Program mode and erase mode are never both 1. A write with bits 1 and 0 both set leaves bits [3:0] unchanged but still updates bits [7:4]. It raises `illegal_wr` for exactly the one cycle that follows.
- R4: The high-voltage bit becomes 1 only when two conditions hold: program or erase mode was already set before the write, and the written value keeps one of them set. A write that clears both mode bits also clears the high-voltage bit.
- R5: The verify bit is never 1 while the high-voltage bit is 1. A write that asks for both stores the verify bit as 0.
- R6: Erase span code 00 selects the whole array (12288 bytes, base 0). Code 01 selects the half (6144 bytes) that contains the recorded offset, with base 0 or 6144. Code 10 selects a 256-byte group, and code 11 selects a 32-byte row. For codes 10 and 11, the base is the recorded offset aligned down to that size.
- R7: The block records an array write offset only while erase mode is 1 and high voltage is 0. Array writes at any other time leave the erase base unchanged.
- R8: Pump divide code 00 gives a pump enable on every bus cycle. Codes 01 and 10 give one every 2 cycles, and code 11 gives one every 4 cycles. Any register write restarts the divider phase.
- R9: A read start with verify off raises `rd_done` for one cycle, 1 cycle after the start is sampled. With verify on, `rd_done` comes 9 cycles after the start (8 extra). Starts that arrive while `rd_busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| illegal_wr | output | 1 | One-cycle flag for a rejected mode write |
| arr_wr | input | 1 | Array write seen on the array path |
| arr_wr_off | input | 14 | Byte offset of that array write |
| rd_start | input | 1 | Array read start |
| rd_busy | output | 1 | A read is in progress |
| rd_done | output | 1 | Read data valid, one cycle |
| prog_mode | output | 1 | Program mode selected |
| erase_mode | output | 1 | Erase mode selected |
| hv_on | output | 1 | High voltage enabled |
| verify_mode | output | 1 | Verify read selected |
| pump_tick | output | 1 | Pump clock enable pulse |
| erase_base | output | 14 | Start offset of the erase region |
| erase_size | output | 15 | Byte length of the erase region |

## Verification
The bench builds the block with its default parameters: a 12288-byte array, 32-byte rows, eight-row groups and an 8-cycle verify stretch. These values make the half-array split fall at offset 6144, which is not a power of two. They also let the bench check, on one chosen offset, the boundaries between the row, group and half granules. The short stretch and the 4-cycle slowest pump divide let the bench count every read latency and every pump pulse exactly.

// File: rtl/fctl_pkg.sv
package fctl_pkg;

  // Field order matches bits 7..0 of the register.
  typedef struct packed {
    logic [1:0] div;
    logic [1:0] span;
    logic       hv;
    logic       verify;
    logic       erase;
    logic       prog;
  } fctl_reg_t;

  localparam int unsigned DIV_SLOWEST = 4;

  function automatic int unsigned div_factor(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01,
      2'b10:   return 2;
      default: return DIV_SLOWEST;
    endcase
  endfunction

endpackage

// File: rtl/fctl_regfile.sv
module fctl_regfile
  import fctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output fctl_reg_t  ctl,
  output logic       illegal
);

  fctl_reg_t w;
  fctl_reg_t cur_q;
  fctl_reg_t nxt;
  logic      ill_q;
  logic      ill_n;

  assign w = fctl_reg_t'(wdata);

  always_comb begin
    nxt   = cur_q;
    ill_n = 1'b0;
    if (wr_en) begin
      nxt.div  = w.div;
      nxt.span = w.span;
      if (w.prog && w.erase) begin
        ill_n = 1'b1;
      end else begin
        nxt.prog   = w.prog;
        nxt.erase  = w.erase;
        nxt.hv     = w.hv && (cur_q.prog || cur_q.erase) && (w.prog || w.erase);
        nxt.verify = w.verify && !nxt.hv;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      ill_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      ill_q <= ill_n;
    end
  end

  assign ctl     = cur_q;
  assign illegal = ill_q;

  assert_modes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.prog && ctl.erase));

  assert_illegal_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[1] && wdata[0]) |=> (illegal && ctl[3:0] == $past(ctl[3:0])));

  assert_hv_needs_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.hv |-> (ctl.prog || ctl.erase));

  assert_hv_rise_after_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.hv && !(ctl.prog || ctl.erase)) |=> !ctl.hv);

  assert_verify_not_with_hv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.verify && ctl.hv));

endmodule

// File: rtl/fctl_pump_div.sv
module fctl_pump_div
  import fctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] div,
  output logic       tick
);

  localparam int CW = $clog2(DIV_SLOWEST);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = CW'(div_factor(div) - 1);
  assign tick = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tick) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assert_slow_div_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div == 2'b11 && !restart) |=> !tick);

  assert_fast_div_every_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (div == 2'b00) |-> tick);

endmodule

// File: rtl/fctl_erase_span.sv
module fctl_erase_span #(
  parameter int OFF_W       = 14,
  parameter int ARRAY_BYTES = 12288,
  parameter int ROW_BYTES   = 32,
  parameter int GROUP_ROWS  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture_ok,
  input  logic           snoop,
  input  logic [OFF_W-1:0] snoop_off,
  input  logic [1:0]     span,
  output logic [OFF_W-1:0] base,
  output logic [OFF_W:0] size
);

  localparam int HALF_BYTES  = ARRAY_BYTES / 2;
  localparam int GROUP_BYTES = ROW_BYTES * GROUP_ROWS;
  localparam logic [OFF_W-1:0] ROW_MASK   = ~OFF_W'(ROW_BYTES - 1);
  localparam logic [OFF_W-1:0] GROUP_MASK = ~OFF_W'(GROUP_BYTES - 1);

  logic [OFF_W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   lat_q <= '0;
    else if (snoop && capture_ok) lat_q <= snoop_off;
  end

  always_comb begin
    case (span)
      2'b00: begin
        base = '0;
        size = (OFF_W+1)'(ARRAY_BYTES);
      end
      2'b01: begin
        base = (lat_q >= OFF_W'(HALF_BYTES)) ? OFF_W'(HALF_BYTES) : '0;
        size = (OFF_W+1)'(HALF_BYTES);
      end
      2'b10: begin
        base = lat_q & GROUP_MASK;
        size = (OFF_W+1)'(GROUP_BYTES);
      end
      default: begin
        base = lat_q & ROW_MASK;
        size = (OFF_W+1)'(ROW_BYTES);
      end
    endcase
  end

  assert_capture_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(snoop && capture_ok) |=> $stable(lat_q));

  assert_base_in_array_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (span != 2'b00) |-> ((OFF_W+1)'(base) + size <= (OFF_W+1)'(ARRAY_BYTES)
                         || lat_q >= OFF_W'(ARRAY_BYTES)));

endmodule

// File: rtl/fctl_rd_stretch.sv
module fctl_rd_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic verify,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(STRETCH + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= verify ? CW'(STRETCH) : '0;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_plain_read_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !verify) |=> done);

endmodule

// File: rtl/fctl_top.sv
module fctl_top
  import fctl_pkg::*;
#(
  parameter int OFF_W       = 14,
  parameter int ARRAY_BYTES = 12288,
  parameter int ROW_BYTES   = 32,
  parameter int GROUP_ROWS  = 8,
  parameter int STRETCH     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             illegal_wr,
  input  logic             arr_wr,
  input  logic [OFF_W-1:0] arr_wr_off,
  input  logic             rd_start,
  output logic             rd_busy,
  output logic             rd_done,
  output logic             prog_mode,
  output logic             erase_mode,
  output logic             hv_on,
  output logic             verify_mode,
  output logic             pump_tick,
  output logic [OFF_W-1:0] erase_base,
  output logic [OFF_W:0]   erase_size
);

  fctl_reg_t ctl;

  fctl_regfile u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wdata   (reg_wdata),
    .ctl     (ctl),
    .illegal (illegal_wr)
  );

  fctl_pump_div u_pump (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (reg_wr),
    .div     (ctl.div),
    .tick    (pump_tick)
  );

  fctl_erase_span #(
    .OFF_W       (OFF_W),
    .ARRAY_BYTES (ARRAY_BYTES),
    .ROW_BYTES   (ROW_BYTES),
    .GROUP_ROWS  (GROUP_ROWS)
  ) u_span (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_ok (ctl.erase && !ctl.hv),
    .snoop      (arr_wr),
    .snoop_off  (arr_wr_off),
    .span       (ctl.span),
    .base       (erase_base),
    .size       (erase_size)
  );

  fctl_rd_stretch #(
    .STRETCH (STRETCH)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rd_start),
    .verify (ctl.verify),
    .busy   (rd_busy),
    .done   (rd_done)
  );

  assign reg_rdata   = ctl;
  assign prog_mode   = ctl.prog;
  assign erase_mode  = ctl.erase;
  assign hv_on       = ctl.hv;
  assign verify_mode = ctl.verify;

endmodule

// File: tb/tb_fctl_top.sv
module tb_fctl_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        illegal_wr;
  logic        arr_wr = 1'b0;
  logic [13:0] arr_wr_off = '0;
  logic        rd_start = 1'b0;
  logic        rd_busy, rd_done;
  logic        prog_mode, erase_mode, hv_on, verify_mode, pump_tick;
  logic [13:0] erase_base;
  logic [14:0] erase_size;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fctl_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .illegal_wr(illegal_wr), .arr_wr(arr_wr),
    .arr_wr_off(arr_wr_off), .rd_start(rd_start), .rd_busy(rd_busy),
    .rd_done(rd_done), .prog_mode(prog_mode), .erase_mode(erase_mode),
    .hv_on(hv_on), .verify_mode(verify_mode), .pump_tick(pump_tick),
    .erase_base(erase_base), .erase_size(erase_size)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic snoop(input int off);
    @(negedge clk);
    arr_wr = 1'b1; arr_wr_off = 14'(off);
    @(negedge clk);
    arr_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 0);
    check("R1 size", erase_size, 12288);
    check("R1 base", erase_base, 0);
    check("R1 busy", rd_busy, 0);
    check("R8 tick div1", pump_tick, 1);
  endtask

  task automatic t_illegal();
    wr(8'h01);
    check("R2 readback", reg_rdata, 8'h01);
    wr(8'hC3);
    check("R3 mode kept", reg_rdata, 8'hC1);
    check("R3 flag", illegal_wr, 1);
    @(negedge clk);
    check("R3 flag one cycle", illegal_wr, 0);
    wr(8'h00);
  endtask

  task automatic t_hv();
    wr(8'h08);
    check("R4 hv w/o mode", reg_rdata, 8'h00);
    wr(8'h02);
    wr(8'h0A);
    check("R4 hv with erase", reg_rdata, 8'h0A);
    wr(8'h08);
    check("R4 hv drops with mode", reg_rdata, 8'h00);
  endtask

  task automatic t_verify();
    wr(8'h01);
    wr(8'h09);
    check("R4 hv with prog", hv_on, 1);
    wr(8'h0D);
    check("R5 verify blocked", reg_rdata, 8'h09);
    wr(8'h05);
    check("R5 verify set", reg_rdata, 8'h05);
    wr(8'h00);
  endtask

  task automatic t_span();
    wr(8'h02);
    snoop(14'h1A57);
    check("R6 full base", erase_base, 0);
    check("R6 full size", erase_size, 12288);
    wr(8'h12);
    check("R6 half base", erase_base, 6144);
    check("R6 half size", erase_size, 6144);
    wr(8'h22);
    check("R6 group base", erase_base, 14'h1A00);
    check("R6 group size", erase_size, 256);
    wr(8'h32);
    check("R6 row base", erase_base, 14'h1A40);
    check("R6 row size", erase_size, 32);
    wr(8'h30);
    snoop(14'h0040);
    check("R7 ignored w/o erase", erase_base, 14'h1A40);
    wr(8'h32);
    wr(8'h3A);
    snoop(14'h0040);
    check("R7 ignored with hv", erase_base, 14'h1A40);
    wr(8'h12);
    snoop(14'h0123);
    check("R6 low half base", erase_base, 0);
    wr(8'h00);
  endtask

  task automatic t_pump();
    for (int code = 0; code < 4; code++) begin
      int n = 0;
      wr(8'(code << 6));
      for (int i = 0; i < 12; i++) begin
        if (pump_tick) n++;
        @(negedge clk);
      end
      check($sformatf("R8 ticks code %0d", code), n, (code == 0) ? 12 : (code == 3) ? 3 : 6);
    end
    wr(8'h00);
  endtask

  task automatic rd_lat(input string req, input int exp);
    int n = 1;
    @(negedge clk);
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    while (!rd_done && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(req, n, exp);
    @(negedge clk);
    check({req, " single"}, rd_done, 0);
  endtask

  task automatic t_read();
    rd_lat("R9 plain read", 1);
    wr(8'h01);
    wr(8'h05);
    rd_lat("R9 verify read", 9);
    @(negedge clk);
    rd_start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_start = 1'b0;
    for (int i = 0; i < 8; i++) @(negedge clk);
    check("R9 start while busy ignored", rd_busy, 0);
    wr(8'h00);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_hv();
    t_verify();
    t_span();
    t_pump();
    t_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule